// File: doc/BRIEF.md
# Automatic Phase Clock Tap Selector

This block chooses which of seven phase-shifted copies of the system clock should retime a circuit whose output has started to lag because of wear. The taps are evenly spaced at 0°, 50°, 100°, 150°, 200°, 250° and 300°. A lag sensor reports how far the circuit's output trails the tap now in use as a 7-bit code with a valid strobe. While correction is enabled, the selector moves its tap forward until the code it reads back is all zeros.

The selector only picks a tap; it does not generate or switch clocks. Its outputs are a binary tap index and a one-hot select, which an ordinary glitch-free clock multiplexer consumes, plus a status flag that says the last reading showed no lag. The choice is held between sensor readings and whenever correction is disabled. Because the code is always measured against the current tap, the selector works as a closed loop: it keeps retuning as the lag grows for as long as enable stays high.

Top module: `phase_tap_selector`

## Requirements
- R1: While `rst` is high at a rising clock edge, the next state is tap index 0 (0°), `tap_sel` = 7'b0000001 and `corrected` = 0.
- R2: When `enable` is low, `tap_idx` and `corrected` keep their values whatever `code_valid` and `aging_code` carry.
- R3: When `code_valid` is low, `tap_idx` and `corrected` keep their values whatever `aging_code` carries.
- R4: In `aging_code`, bit i (i = 0..5) set means the lag beyond the current tap exceeds (i+1)·50°, and bit 6 set means the tap is ahead of the signal (over-correction). On a reading with bit 6 clear and a nonzero value, the index advances by the number of set bits among bits 5..0. For example, a 108° lag read at tap 0 gives 0x03 and selects index 2 (100°), and a 220° lag gives 0x0F and selects index 4 (200°).
- R5: The index saturates at 6 (300°) and never exceeds it.
- R6: A reading with bit 6 set moves the index down by one, stopping at 0, and clears `corrected`.
- R7: A reading of 0x00 keeps the tap and sets `corrected`. Any nonzero reading clears `corrected`.
- R8: `tap_sel` is always one-hot, with bit `tap_idx` set.
- R9: A reading taken at a rising edge with `enable` and `code_valid` high shows on `tap_idx`, `tap_sel` and `corrected` right after that edge.
- R10: Successive readings accumulate, so a lag that keeps growing is followed one step per reading while `enable` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Allows correction while high |
| code_valid | input | 1 | One-cycle strobe marking a fresh sensor reading |
| aging_code | input | 7 | Lag reading relative to the current tap (bits 5..0 are thresholds, bit 6 is the over-correction flag) |
| tap_idx | output | 3 | Selected tap, 0..6 for 0°..300° |
| tap_sel | output | 7 | One-hot form of `tap_idx` for a clock multiplexer |
| corrected | output | 1 | High after a reading that showed no lag |

## Verification
The assertions take the sensor code only as sampled on a valid reading with correction enabled. They treat any bit pattern as legal and put no limit on how often readings arrive. The stimulus therefore goes beyond well-formed thermometer codes. It sends codes with gaps between set bits and codes that would carry the index past 300°. It asserts the over-correction bit at the lowest tap. It sends back-to-back readings with no idle cycle between them. It changes `aging_code` while `enable` or `code_valid` is low, so the hold behaviour is exercised against changing data. A sweep resets the block and applies every threshold pattern once from 0°.

// File: rtl/tap_sel_pkg.sv
package tap_sel_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD    = 2'd0,
    ACT_SETTLE  = 2'd1,
    ACT_ADVANCE = 2'd2,
    ACT_RETREAT = 2'd3
  } tap_act_e;

  // Number of set bits in a vector of up to 32 bits.
  function automatic int unsigned count_ones(input logic [31:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 32; i++) begin
      n += v[i] ? 1 : 0;
    end
    return n;
  endfunction

  // Addition clamped to an upper limit.
  function automatic int unsigned add_clamped(input int unsigned base,
                                              input int unsigned inc,
                                              input int unsigned limit);
    int unsigned sum;
    sum = base + inc;
    return (sum > limit) ? limit : sum;
  endfunction

  // Subtract one, stopping at zero.
  function automatic int unsigned dec_floor(input int unsigned base);
    return (base == 0) ? 0 : base - 1;
  endfunction

endpackage

// File: rtl/tap_code_decode.sv
module tap_code_decode
  import tap_sel_pkg::*;
#(
  parameter int TAPS = 7,
  localparam int IDX_W = $clog2(TAPS)
) (
  input  logic             enable,
  input  logic             code_valid,
  input  logic [TAPS-1:0]  aging_code,
  output tap_act_e         act,
  output logic [IDX_W-1:0] step
);

  localparam int LAG_BITS = TAPS - 1;

  logic [LAG_BITS-1:0] lag_bits;
  logic                lead_bit;
  logic                reading;

  assign lag_bits = aging_code[LAG_BITS-1:0];
  assign lead_bit = aging_code[TAPS-1];
  assign reading  = enable & code_valid;

  always_comb begin
    step = IDX_W'(count_ones(32'(lag_bits)));
    if (!reading)               act = ACT_HOLD;
    else if (aging_code == '0)  act = ACT_SETTLE;
    else if (lead_bit)          act = ACT_RETREAT;
    else                        act = ACT_ADVANCE;
  end

endmodule

// File: rtl/tap_index_reg.sv
module tap_index_reg
  import tap_sel_pkg::*;
#(
  parameter int TAPS = 7,
  localparam int IDX_W = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  tap_act_e         act,
  input  logic [IDX_W-1:0] step,
  output logic [IDX_W-1:0] tap_idx,
  output logic             corrected
);

  localparam int unsigned MAX_IDX = TAPS - 1;

  logic [IDX_W-1:0] idx_fwd;
  logic [IDX_W-1:0] idx_back;

  always_comb begin
    idx_fwd  = IDX_W'(add_clamped(int'(tap_idx), int'(step), MAX_IDX));
    idx_back = IDX_W'(dec_floor(int'(tap_idx)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_idx   <= '0;
      corrected <= 1'b0;
    end else begin
      case (act)
        ACT_SETTLE: corrected <= 1'b1;
        ACT_ADVANCE: begin
          tap_idx   <= idx_fwd;
          corrected <= 1'b0;
        end
        ACT_RETREAT: begin
          tap_idx   <= idx_back;
          corrected <= 1'b0;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/tap_onehot.sv
module tap_onehot #(
  parameter int TAPS = 7,
  localparam int IDX_W = $clog2(TAPS)
) (
  input  logic [IDX_W-1:0] tap_idx,
  output logic [TAPS-1:0]  tap_sel
);

  for (genvar g = 0; g < TAPS; g++) begin : g_line
    assign tap_sel[g] = (tap_idx == IDX_W'(g));
  end

endmodule

// File: rtl/phase_tap_selector.sv
module phase_tap_selector
  import tap_sel_pkg::*;
#(
  parameter int TAPS = 7,
  localparam int IDX_W = $clog2(TAPS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             code_valid,
  input  logic [TAPS-1:0]  aging_code,
  output logic [IDX_W-1:0] tap_idx,
  output logic [TAPS-1:0]  tap_sel,
  output logic             corrected
);

  // Decoded action and step size, named for the checker.
  tap_act_e         act;
  logic [IDX_W-1:0] step;

  tap_code_decode #(.TAPS(TAPS)) u_decode (
    .enable     (enable),
    .code_valid (code_valid),
    .aging_code (aging_code),
    .act        (act),
    .step       (step)
  );

  tap_index_reg #(.TAPS(TAPS)) u_state (
    .clk       (clk),
    .rst       (rst),
    .act       (act),
    .step      (step),
    .tap_idx   (tap_idx),
    .corrected (corrected)
  );

  tap_onehot #(.TAPS(TAPS)) u_onehot (
    .tap_idx (tap_idx),
    .tap_sel (tap_sel)
  );

endmodule

// File: rtl/tap_sel_checker.sv
module tap_sel_checker
  import tap_sel_pkg::*;
#(
  parameter int TAPS = 7,
  localparam int IDX_W = $clog2(TAPS)
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic             code_valid,
  input logic [TAPS-1:0]  aging_code,
  input logic [IDX_W-1:0] tap_idx,
  input logic [TAPS-1:0]  tap_sel,
  input logic             corrected,
  input tap_act_e         act
);

  localparam logic [IDX_W-1:0] MAX_IDX = IDX_W'(TAPS - 1);

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (tap_idx == '0) && !corrected);

  assert_hold_disabled_R2: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(tap_idx) && $stable(corrected));

  assert_hold_novalid_R3: assert property (@(posedge clk) disable iff (rst)
    !code_valid |=> $stable(tap_idx) && $stable(corrected));

  assert_advance_moves_R4: assert property (@(posedge clk) disable iff (rst)
    (act == ACT_ADVANCE) |=> (tap_idx > $past(tap_idx)) || (tap_idx == MAX_IDX));

  assert_index_bound_R5: assert property (@(posedge clk) disable iff (rst)
    tap_idx <= MAX_IDX);

  assert_retreat_step_R6: assert property (@(posedge clk) disable iff (rst)
    (enable && code_valid && aging_code[TAPS-1] && tap_idx != '0)
      |=> (tap_idx == $past(tap_idx) - 1'b1) && !corrected);

  assert_settle_flag_R7: assert property (@(posedge clk) disable iff (rst)
    (enable && code_valid && aging_code == '0) |=> corrected && $stable(tap_idx));

  assert_onehot_match_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tap_sel) && tap_sel[tap_idx]);

endmodule

bind phase_tap_selector tap_sel_checker #(.TAPS(TAPS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .enable     (enable),
  .code_valid (code_valid),
  .aging_code (aging_code),
  .tap_idx    (tap_idx),
  .tap_sel    (tap_sel),
  .corrected  (corrected),
  .act        (act)
);

// File: tb/sim_phase_tap_selector.sv
`timescale 1ns/1ps
module sim_phase_tap_selector;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       enable = 1'b0;
  logic       code_valid = 1'b0;
  logic [6:0] aging_code = '0;
  logic [2:0] tap_idx;
  logic [6:0] tap_sel;
  logic       corrected;

  int checks = 0;
  int failures = 0;
  int m_tap = 0;
  bit m_corr = 1'b0;

  always #4 clk = ~clk;

  phase_tap_selector u0 (
    .clk(clk), .rst(rst), .enable(enable), .code_valid(code_valid),
    .aging_code(aging_code), .tap_idx(tap_idx), .tap_sel(tap_sel),
    .corrected(corrected)
  );

  // Behavioural reference: next state from the requirement text.
  task automatic model_step(input bit r, input bit en, input bit v, input logic [6:0] c);
    int lags;
    if (r) begin
      m_tap = 0; m_corr = 1'b0;
    end else if (en && v) begin
      if (c == 7'h00) m_corr = 1'b1;
      else if (c[6]) begin
        m_tap = (m_tap > 0) ? m_tap - 1 : 0;
        m_corr = 1'b0;
      end else begin
        lags = 0;
        for (int i = 0; i < 6; i++) if (c[i]) lags++;
        m_tap = m_tap + lags;
        if (m_tap > 6) m_tap = 6;
        m_corr = 1'b0;
      end
    end
  endtask

  task automatic compare(input string tag);
    logic [6:0] exp_sel;
    exp_sel = 7'b1 << m_tap;
    checks++;
    if (tap_idx !== 3'(m_tap) || tap_sel !== exp_sel || corrected !== m_corr) begin
      failures++;
      $display("FAIL %s: idx=%0d sel=%b corr=%b expected idx=%0d sel=%b corr=%b",
               tag, tap_idx, tap_sel, corrected, m_tap, exp_sel, m_corr);
    end
  endtask

  // Called at a falling edge: drive, advance model, check at next falling edge.
  task automatic cycle(input bit r, input bit en, input bit v,
                       input logic [6:0] c, input string tag);
    rst = r; enable = en; code_valid = v; aging_code = c;
    model_step(r, en, v, c);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    @(negedge clk);
    cycle(1, 0, 0, 7'h00, "R1 reset");
    cycle(1, 1, 1, 7'h3F, "R1 reset dominates reading");
    cycle(0, 1, 1, 7'h03, "R4 108deg lag -> 100deg, R9 latency");
    cycle(0, 1, 1, 7'h00, "R7 zero reading sets corrected");
    cycle(0, 0, 1, 7'h3F, "R2 enable low holds");
    cycle(0, 0, 0, 7'h7F, "R2 enable low, code changing");
    cycle(0, 1, 0, 7'h3F, "R3 no valid holds");
    cycle(0, 1, 1, 7'h05, "R4 gapped code advances by set count");
    cycle(0, 1, 1, 7'h0F, "R5 saturate at 300deg");
    cycle(0, 1, 1, 7'h01, "R5 stays at 300deg");
    cycle(0, 1, 1, 7'h7F, "R6 over-correction steps back");
    cycle(0, 1, 1, 7'h00, "R7 settle after retreat");
    cycle(0, 1, 1, 7'h20, "R7 nonzero clears corrected, R4 single bit");
    cycle(1, 0, 0, 7'h00, "R1 reset mid-run");
    cycle(0, 1, 1, 7'h7F, "R6 over-correction at 0deg stays");
    cycle(0, 1, 1, 7'h0F, "R4 220deg lag -> 200deg");
    // Growing lag tracked reading after reading.
    cycle(1, 0, 0, 7'h00, "R1 reset before tracking");
    for (int k = 0; k < 6; k++) begin
      cycle(0, 1, 1, 7'h01, "R10 lag grows one step");
      cycle(0, 1, 1, 7'h00, "R10 settled between steps");
      cycle(0, 1, 0, 7'h00, "R3 idle cycle");
    end
    // Sweep every threshold pattern from 0deg.
    for (int c = 0; c < 64; c++) begin
      cycle(1, 0, 0, 7'h00, "R1 sweep reset");
      cycle(0, 1, 1, 7'(c), "R4 R5 R8 sweep");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule